// File: doc/BRIEF.md
# Write Byte-Mask Sequencer

This block commits buffered write data to storage and decides, for each write, which of its 16 bytes reach storage. A write command opens a pending window. The 16-byte data packet arrives during that window on two 8-byte lane groups, low and high. A fixed number of cycles after the write command, a secondary column packet arrives in the write's own slot. That packet can take one of two forms. When its mask flag is set, it carries two 8-bit byte masks, one for each lane group. When the flag is clear, it carries an extended command opcode that belongs to other logic.

In the retire slot the block combines the buffered data with the decoded mask. It then issues one storage write with 16 per-byte enables. A slot without a mask, or with no packet at all, commits all 16 bytes. Reads take no mask, so a secondary packet outside a write's slot is always forwarded as an extended command. The block holds one write at a time. A write whose data has not arrived by its slot is dropped, and this raises a sticky error flag.

Top module: `wms_seq`

## Requirements
- R1: After the asynchronous active-low reset, `wr_en_o`, `xop_valid_o` and `err_o` are 0.
- R2: A write command accepted at clock edge t has its retire slot at edge t+RETIRE_DLY. If its data was captured, `wr_en_o` is 1 for exactly the cycle after that edge, and `wr_addr_o` equals the command's address.
- R3: Committed byte i (0..7) is `data_lo_i[8i+7:8i]`, and committed byte 8+i is `data_hi_i[8i+7:8i]`. `wr_data_o` holds byte k in bits 8k+7:8k.
- R4: If the slot packet has `sec_valid_i`=1 and `sec_mask_i`=1, then `wr_be_o` = {`sec_mask_hi_i`, `sec_mask_lo_i`}. A bit of 1 writes its byte and a bit of 0 suppresses it.
- R5: If the slot packet has `sec_valid_i`=1 and `sec_mask_i`=0, then `wr_be_o` is all ones, and `xop_valid_o` pulses in the same cycle with `xop_o` equal to `sec_xop_i`.
- R6: A secondary packet at an edge that is not a write's retire slot, such as a read's slot, is forwarded as an extended command even when its mask flag is set. It causes no commit.
- R7: If `sec_valid_i`=0 at the retire slot, the write commits with all 16 enables and `xop_valid_o` stays 0.
- R8: A write whose data did not arrive by its slot is not committed. `err_o` then goes to 1 and stays there until reset.
- R9: Only the first data packet captured strictly after the command edge and strictly before the slot edge is kept. Later packets, and packets that arrive when no write is pending, are ignored.
- R10: A write command that arrives while a write is pending, other than at that write's slot edge, is ignored. A write command at the slot edge is accepted.
- R11: `wr_addr_o`, `wr_data_o` and `wr_be_o` change only with a commit. `xop_o` changes only with `xop_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Column command present |
| cmd_wr_i | input | 1 | 1 = write command, 0 = read |
| cmd_addr_i | input | ADDR_W | Column address of the command |
| data_valid_i | input | 1 | Write data packet present |
| data_lo_i | input | 8*LANE_BYTES | Low lane group, bytes 0..7 |
| data_hi_i | input | 8*LANE_BYTES | High lane group, bytes 8..15 |
| sec_valid_i | input | 1 | Secondary column packet present |
| sec_mask_i | input | 1 | Mask flag of the secondary packet |
| sec_mask_lo_i | input | LANE_BYTES | Mask for the low lane group |
| sec_mask_hi_i | input | LANE_BYTES | Mask for the high lane group |
| sec_xop_i | input | XOP_W | Extended command opcode |
| wr_en_o | output | 1 | Storage write strobe |
| wr_addr_o | output | ADDR_W | Storage write address |
| wr_data_o | output | 16*LANE_BYTES | Storage write data |
| wr_be_o | output | 2*LANE_BYTES | Per-byte write enables |
| xop_valid_o | output | 1 | Extended command strobe |
| xop_o | output | XOP_W | Extended command opcode |
| err_o | output | 1 | Sticky missing-data error |

## Verification
The assertions assume only a clean reset and RETIRE_DLY of at least 1. Beyond that they hold for any input sequence, including packets that collide, repeat or arrive out of place. The stimulus therefore starts with directed cases that place data and secondary packets exactly at, before and after the retire slot. It then drives every input independently at random, so that writes land while another write is pending, data goes missing, and mask-flagged packets fall outside write slots. A behavioural model predicts every output on every cycle.

// File: rtl/wms_pkg.sv
package wms_pkg;
  typedef enum logic [1:0] {
    SLOT_NONE  = 2'd0,
    SLOT_MASK  = 2'd1,
    SLOT_XCMD  = 2'd2,
    SLOT_EMPTY = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/wms_slot_timer.sv
module wms_slot_timer #(
  parameter int RETIRE_DLY = 4,
  parameter int ADDR_W     = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic              cmd_wr_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              pending_o,
  output logic              start_o,
  output logic              slot_o,
  output logic [ADDR_W-1:0] slot_addr_o
);
  localparam int CW = (RETIRE_DLY > 1) ? $clog2(RETIRE_DLY) : 1;

  logic [CW-1:0]     cnt_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  assign slot_o      = pend_q && (cnt_q == CW'(RETIRE_DLY - 1));
  assign start_o     = cmd_valid_i && cmd_wr_i && (!pend_q || slot_o);
  assign pending_o   = pend_q;
  assign slot_addr_o = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (start_o) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      addr_q <= cmd_addr_i;
    end else if (slot_o) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (int'(cnt_q) < RETIRE_DLY));
endmodule

// File: rtl/wms_data_buf.sv
module wms_data_buf #(
  parameter int LANE_BYTES = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      pending_i,
  input  logic                      slot_i,
  input  logic                      data_valid_i,
  input  logic [8*LANE_BYTES-1:0]   data_lo_i,
  input  logic [8*LANE_BYTES-1:0]   data_hi_i,
  output logic                      have_o,
  output logic [16*LANE_BYTES-1:0]  data_o
);
  logic                     have_q;
  logic [16*LANE_BYTES-1:0] data_q;
  logic                     take;

  // first packet inside the open window only
  assign take   = pending_i && !slot_i && !have_q && data_valid_i;
  assign have_o = have_q;
  assign data_o = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      data_q <= '0;
    end else if (start_i) begin
      have_q <= 1'b0;
    end else if (take) begin
      have_q <= 1'b1;
      data_q <= {data_hi_i, data_lo_i};
    end
  end

  p_hold_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !start_i) |=> $stable(data_q));
endmodule

// File: rtl/wms_mask_decode.sv
module wms_mask_decode
  import wms_pkg::*;
#(
  parameter int LANE_BYTES = 8
) (
  input  logic                    slot_i,
  input  logic                    sec_valid_i,
  input  logic                    sec_mask_i,
  input  logic [LANE_BYTES-1:0]   mask_lo_i,
  input  logic [LANE_BYTES-1:0]   mask_hi_i,
  output slot_kind_e              kind_o,
  output logic [2*LANE_BYTES-1:0] be_o,
  output logic                    xcmd_o
);
  always_comb begin
    if (!slot_i)          kind_o = SLOT_NONE;
    else if (!sec_valid_i) kind_o = SLOT_EMPTY;
    else if (sec_mask_i)   kind_o = SLOT_MASK;
    else                   kind_o = SLOT_XCMD;
  end

  assign be_o   = (kind_o == SLOT_MASK) ? {mask_hi_i, mask_lo_i} : '1;
  // anything not consumed as a mask is an extended command
  assign xcmd_o = sec_valid_i && (kind_o != SLOT_MASK);
endmodule

// File: rtl/wms_seq.sv
module wms_seq
  import wms_pkg::*;
#(
  parameter int RETIRE_DLY = 4,
  parameter int ADDR_W     = 12,
  parameter int LANE_BYTES = 8,
  parameter int XOP_W      = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_wr_i,
  input  logic [ADDR_W-1:0]        cmd_addr_i,
  input  logic                     data_valid_i,
  input  logic [8*LANE_BYTES-1:0]  data_lo_i,
  input  logic [8*LANE_BYTES-1:0]  data_hi_i,
  input  logic                     sec_valid_i,
  input  logic                     sec_mask_i,
  input  logic [LANE_BYTES-1:0]    sec_mask_lo_i,
  input  logic [LANE_BYTES-1:0]    sec_mask_hi_i,
  input  logic [XOP_W-1:0]         sec_xop_i,
  output logic                     wr_en_o,
  output logic [ADDR_W-1:0]        wr_addr_o,
  output logic [16*LANE_BYTES-1:0] wr_data_o,
  output logic [2*LANE_BYTES-1:0]  wr_be_o,
  output logic                     xop_valid_o,
  output logic [XOP_W-1:0]         xop_o,
  output logic                     err_o
);
  localparam int BE_W = 2 * LANE_BYTES;

  logic                     pending, start, slot, have, xcmd;
  logic [ADDR_W-1:0]        slot_addr;
  logic [16*LANE_BYTES-1:0] buf_data;
  logic [BE_W-1:0]          be;
  slot_kind_e               kind;

  wms_slot_timer #(.RETIRE_DLY(RETIRE_DLY), .ADDR_W(ADDR_W)) u_timer (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_wr_i, .cmd_addr_i,
    .pending_o(pending), .start_o(start), .slot_o(slot), .slot_addr_o(slot_addr)
  );

  wms_data_buf #(.LANE_BYTES(LANE_BYTES)) u_buf (
    .clk_i, .rst_ni, .start_i(start), .pending_i(pending), .slot_i(slot),
    .data_valid_i, .data_lo_i, .data_hi_i, .have_o(have), .data_o(buf_data)
  );

  wms_mask_decode #(.LANE_BYTES(LANE_BYTES)) u_dec (
    .slot_i(slot), .sec_valid_i, .sec_mask_i,
    .mask_lo_i(sec_mask_lo_i), .mask_hi_i(sec_mask_hi_i),
    .kind_o(kind), .be_o(be), .xcmd_o(xcmd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      wr_be_o     <= '0;
      xop_valid_o <= 1'b0;
      xop_o       <= '0;
      err_o       <= 1'b0;
    end else begin
      wr_en_o     <= slot && have;
      xop_valid_o <= xcmd;
      if (slot && have) begin
        wr_addr_o <= slot_addr;
        wr_data_o <= buf_data;
        wr_be_o   <= be;
      end
      if (xcmd) xop_o <= sec_xop_i;
      if (slot && !have) err_o <= 1'b1;
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_err_no_commit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !wr_en_o);
  p_xop_unmasked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && xop_valid_o) |-> (wr_be_o == '1));
  p_slot_kind_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == SLOT_MASK) |-> !xcmd);
endmodule

// File: tb/wms_seq_tb.sv
module wms_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4;
  localparam int AW  = 12;
  localparam int LB  = 8;
  localparam int XW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_v = 0, cmd_wr = 0, dv = 0, sv = 0, sflag = 0;
  logic [AW-1:0] caddr = '0;
  logic [8*LB-1:0] dlo = '0, dhi = '0;
  logic [LB-1:0] mlo = '0, mhi = '0;
  logic [XW-1:0] sxop = '0;
  logic wr_en, xv, err;
  logic [AW-1:0] wr_addr;
  logic [16*LB-1:0] wr_data;
  logic [2*LB-1:0] wr_be;
  logic [XW-1:0] xop;

  int checks = 0, fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wms_seq #(.RETIRE_DLY(DLY), .ADDR_W(AW), .LANE_BYTES(LB), .XOP_W(XW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_v), .cmd_wr_i(cmd_wr),
    .cmd_addr_i(caddr), .data_valid_i(dv), .data_lo_i(dlo), .data_hi_i(dhi),
    .sec_valid_i(sv), .sec_mask_i(sflag), .sec_mask_lo_i(mlo), .sec_mask_hi_i(mhi),
    .sec_xop_i(sxop), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_be_o(wr_be), .xop_valid_o(xv), .xop_o(xop), .err_o(err)
  );

  // behavioural model
  bit m_pend, m_have;
  int m_age;
  logic [AW-1:0] m_addr;
  logic [7:0] m_bytes [16];
  logic e_en, e_xv, e_err;
  logic [AW-1:0] e_addr;
  logic [7:0] e_bytes [16];
  logic [15:0] e_be;
  logic [XW-1:0] e_xop;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_have = 0; m_age = 0; m_addr = '0;
      e_en = 0; e_xv = 0; e_err = 0; e_addr = '0; e_be = '0; e_xop = '0;
      for (int k = 0; k < 16; k++) begin m_bytes[k] = 8'h0; e_bytes[k] = 8'h0; end
    end else begin
      bit at_slot;
      at_slot = m_pend && (m_age == DLY - 1);
      e_en = at_slot && m_have;
      if (at_slot && !m_have) e_err = 1;
      if (e_en) begin
        e_addr = m_addr;
        for (int k = 0; k < 16; k++) e_bytes[k] = m_bytes[k];
        e_be = (sv && sflag) ? {mhi, mlo} : 16'hFFFF;
      end
      e_xv = sv && !(at_slot && sflag);
      if (e_xv) e_xop = sxop;
      if (m_pend && !at_slot && !m_have && dv) begin
        m_have = 1;
        for (int k = 0; k < 8; k++) begin
          m_bytes[k]   = dlo[8*k +: 8];
          m_bytes[k+8] = dhi[8*k +: 8];
        end
      end
      if (m_pend) m_age++;
      if (at_slot) m_pend = 0;
      if (cmd_v && cmd_wr && (!m_pend || at_slot)) begin
        m_pend = 1; m_age = 0; m_have = 0; m_addr = caddr;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [127:0] eb;
      for (int k = 0; k < 16; k++) eb[8*k +: 8] = e_bytes[k];
      chk(wr_en === e_en, "R2 R10 wr_en", 128'(wr_en), 128'(e_en));
      chk(wr_addr === e_addr, "R2 R11 wr_addr", 128'(wr_addr), 128'(e_addr));
      chk(wr_data === eb, "R3 R9 wr_data", wr_data, eb);
      chk(wr_be === e_be, "R4 R5 R7 wr_be", 128'(wr_be), 128'(e_be));
      chk(xv === e_xv, "R5 R6 R7 xop_valid", 128'(xv), 128'(e_xv));
      chk(xop === e_xop, "R5 R11 xop", 128'(xop), 128'(e_xop));
      chk(err === e_err, "R8 err", 128'(err), 128'(e_err));
    end
  end

  task automatic idle();
    cmd_v = 0; dv = 0; sv = 0; sflag = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); idle(); end
  endtask

  // write at this cycle, data after dgap (0 = none), secondary packet kind at slot
  task automatic wr_seq(input logic [AW-1:0] a, input int dgap, input int sk,
                        input logic [7:0] ml, input logic [7:0] mh, input logic [XW-1:0] op);
    cmd_v = 1; cmd_wr = 1; caddr = a;
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk); idle();
      if (i == dgap) begin
        dv = 1; dlo = {$urandom, $urandom}; dhi = {$urandom, $urandom};
      end
      if (i == DLY && sk != 0) begin
        sv = 1; sflag = (sk == 1); mlo = ml; mhi = mh; sxop = op;
      end
    end
    @(negedge clk); idle();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wr_en === 0 && xv === 0 && err === 0, "R1 reset outputs",
        128'({wr_en, xv, err}), 128'(0));
    rst_n = 1;
    @(negedge clk);
    wr_seq(12'h011, 1, 2, 8'h00, 8'h00, 5'h05);      // R5 flag clear
    tick(2);
    wr_seq(12'h022, 2, 1, 8'h0F, 8'hA5, 5'h09);      // R4 masked
    tick(1);
    wr_seq(12'h033, DLY-1, 0, 8'h00, 8'h00, 5'h00);  // R7 no packet
    tick(1);
    wr_seq(12'h044, 1, 1, 8'h00, 8'h00, 5'h01);      // R4 all suppressed
    // R6: read with mask-flagged packet at its slot
    cmd_v = 1; cmd_wr = 0; caddr = 12'h055;
    tick(DLY);
    sv = 1; sflag = 1; mlo = 8'h33; mhi = 8'h44; sxop = 5'h1E;
    tick(2);
    // R9: two data packets, then one outside any window
    cmd_v = 1; cmd_wr = 1; caddr = 12'h066;
    @(negedge clk); idle(); dv = 1; dlo = 64'h0706050403020100; dhi = 64'h0F0E0D0C0B0A0908;
    @(negedge clk); idle(); dv = 1; dlo = '1; dhi = '1;
    tick(DLY);
    dv = 1; dlo = 64'hDEAD; tick(2);
    // R10: write inside window ignored, write at slot edge accepted
    cmd_v = 1; cmd_wr = 1; caddr = 12'h077;
    @(negedge clk); idle(); dv = 1; dlo = 64'h1111; dhi = 64'h2222;
    @(negedge clk); idle(); cmd_v = 1; cmd_wr = 1; caddr = 12'h0EE;
    tick(DLY - 2);
    cmd_v = 1; cmd_wr = 1; caddr = 12'h088;
    @(negedge clk); idle(); dv = 1; dlo = 64'h3333; dhi = 64'h4444;
    tick(DLY + 1);
    // R8: missing data
    wr_seq(12'h099, 0, 2, 8'h00, 8'h00, 5'h03);
    tick(2);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      cmd_v = ($urandom_range(0, 3) == 0); cmd_wr = $urandom_range(0, 1);
      caddr = AW'($urandom);
      dv = ($urandom_range(0, 2) == 0); dlo = {$urandom, $urandom}; dhi = {$urandom, $urandom};
      sv = ($urandom_range(0, 2) == 0); sflag = $urandom_range(0, 1);
      mlo = 8'($urandom); mhi = 8'($urandom); sxop = XW'($urandom);
      @(negedge clk);
    end
    idle();
    tick(DLY + 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule